// File: doc/BRIEF.md
# Framed Packet Encoder and Serializer

This block turns a buffer of payload bytes into one framed bit stream on a single-bit link. A select input starts a frame. The block captures the destination address and the payload length, then drives the frame out one bit per clock, most significant bit first. The frame has three parts in a fixed order: a 32-bit synchronization word, a start-of-frame packet and a data packet.

The start-of-frame packet holds a self-checking packet identifier, the address, the length and a CRC. The data packet holds its own identifier, the payload bytes and a second CRC. The payload comes from a byte-wide memory port with a combinational read: the block presents an index and takes the byte in the same cycle. Each CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF. It has no final inversion and starts again for each packet.

Top module: `frame_serializer`

## Requirements
- R1: While reset is held, and while idle after reset, `busy_o`, `ser_valid_o` and `ser_o` are 0.
- R2: When `sel_i` is 1 at a clock edge while the block is idle, the serial stream starts in the next cycle with the word 0xAAAA5555, MSB first.
- R3: A packet identifier is 8 bits. Its upper nibble is the packet type and its lower nibble is the ones' complement of that type. The start-of-frame identifier (type 1) is 0x1E and follows the sync word. The data identifier (type 2) is 0x2D and follows the start-of-frame CRC.
- R4: After the start-of-frame identifier come the 32-bit address and then the 16-bit length, both as captured at the starting edge.
- R5: The start-of-frame CRC is 16 bits and follows the length. It is computed MSB first over the address bits and then the length bits, from a seed of 0xFFFF, with polynomial 0x1021 and no final XOR.
- R6: After the data identifier come `len` payload bytes, MSB first. Byte k is the value on `rd_data_i` in the cycle when `rd_addr_o` equals k, for k = 0 up to len-1 in increasing order.
- R7: The data CRC follows the last payload byte. It uses the same algorithm as R5, restarted at 0xFFFF, over the payload bits only. For the ASCII payload "123456789" it is 0x29B1.
- R8: With a length of 0, the data identifier is followed directly by the data CRC, which is 0xFFFF.
- R9: `busy_o` and `ser_valid_o` stay high for exactly 128 + 8·len consecutive cycles, which ends with the last data CRC bit, and no bits are sent outside that window.
- R10: While busy, a pulse on `sel_i` and any change on `addr_i` or `len_i` have no effect on the frame in progress, and no extra frame follows.
- R11: If `sel_i` is held high, the next frame starts after exactly one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Starts a frame when sampled high while idle |
| addr_i | input | 32 | Destination address, captured at start |
| len_i | input | 16 | Payload byte count, captured at start |
| rd_addr_o | output | 16 | Index of the payload byte being read |
| rd_data_i | input | 8 | Payload byte at `rd_addr_o`, combinational |
| ser_o | output | 1 | Serial frame bit |
| ser_valid_o | output | 1 | High while `ser_o` carries a frame bit |
| busy_o | output | 1 | High for the whole frame |

## Verification
Frames are sent with lengths of 0, 1, 4, 9 and 20 bytes. The zero-length frame shows whether the payload stage is skipped cleanly. The one-byte frame exposes off-by-one errors in the byte index. The 9-byte ASCII "123456789" frame pins the CRC against a published check value rather than only against the bench's own model. One long frame has a select pulse and changed address and length inputs injected mid-frame, which separates a correct capture from one that follows its inputs. A run with select held high measures the idle gap between two frames.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int SH_W = 32;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 16;
  localparam int PID_W = 8;
  localparam logic [SH_W-1:0]  SYNC_WORD = 32'hAAAA_5555;
  localparam logic [CRC_W-1:0] CRC_POLY  = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED  = 16'hFFFF;
  localparam logic [3:0]       TYPE_SOF  = 4'h1;
  localparam logic [3:0]       TYPE_DAT  = 4'h2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SYNC, ST_SOF_PID, ST_ADDR, ST_LEN,
    ST_SOF_CRC, ST_DAT_PID, ST_PAYLOAD, ST_DAT_CRC
  } fld_e;

  function automatic logic [PID_W-1:0] make_pid(input logic [3:0] kind);
    return {kind, ~kind};
  endfunction

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/frm_crc16.sv
module frm_crc16
  import frm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o,
  output logic [CRC_W-1:0] crc_next_o
);
  logic [CRC_W-1:0] crc_q;

  assign crc_o      = crc_q;
  assign crc_next_o = en_i ? crc_step(crc_q, bit_i) : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= CRC_SEED;
    else if (clear_i) crc_q <= CRC_SEED;
    else              crc_q <= crc_next_o;
  end
endmodule

// File: rtl/frm_shifter.sv
module frm_shifter
  import frm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [SH_W-1:0] val_i,
  input  logic            shift_en_i,
  output logic            ser_o
);
  logic [SH_W-1:0] sh_q;

  assign ser_o = sh_q[SH_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sh_q <= '0;
    else if (load_i)     sh_q <= val_i;
    else if (shift_en_i) sh_q <= {sh_q[SH_W-2:0], 1'b0};
  end

  // R1: the line idles low whenever nothing is being loaded or shifted
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_i && !load_i) |-> !ser_o);
endmodule

// File: rtl/frm_fsm.sv
module frm_fsm
  import frm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  input  logic [CRC_W-1:0]  crc_next_i,
  output logic [LEN_W-1:0]  rd_addr_o,
  output logic              load_o,
  output logic [SH_W-1:0]   load_val_o,
  output logic              crc_clear_o,
  output logic              hash_en_o,
  output logic              busy_o,
  output fld_e              state_o
);
  localparam int CW = $clog2(SH_W);

  fld_e              st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, idx_q, idx_d;
  logic              start_evt, field_last;

  assign start_evt  = (st_q == ST_IDLE) && sel_i;
  assign field_last = (st_q != ST_IDLE) && (cnt_q == '0);
  assign busy_o     = (st_q != ST_IDLE);
  assign hash_en_o  = (st_q == ST_ADDR) || (st_q == ST_LEN) || (st_q == ST_PAYLOAD);
  assign rd_addr_o  = idx_q;
  assign state_o    = st_q;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    load_o      = 1'b0;
    load_val_o  = '0;
    crc_clear_o = 1'b0;
    if (start_evt) begin
      st_d = ST_SYNC; cnt_d = CW'(SH_W-1); idx_d = '0;
      load_o = 1'b1; load_val_o = SYNC_WORD;
    end else if (field_last) begin
      load_o = 1'b1;
      case (st_q)
        ST_SYNC: begin
          st_d = ST_SOF_PID; cnt_d = CW'(PID_W-1); crc_clear_o = 1'b1;
          load_val_o = {make_pid(TYPE_SOF), {(SH_W-PID_W){1'b0}}};
        end
        ST_SOF_PID: begin
          st_d = ST_ADDR; cnt_d = CW'(ADDR_W-1);
          load_val_o = SH_W'(addr_q) << (SH_W-ADDR_W);
        end
        ST_ADDR: begin
          st_d = ST_LEN; cnt_d = CW'(LEN_W-1);
          load_val_o = SH_W'(len_q) << (SH_W-LEN_W);
        end
        ST_LEN: begin
          st_d = ST_SOF_CRC; cnt_d = CW'(CRC_W-1);
          load_val_o = {crc_next_i, {(SH_W-CRC_W){1'b0}}};
        end
        ST_SOF_CRC: begin
          st_d = ST_DAT_PID; cnt_d = CW'(PID_W-1); crc_clear_o = 1'b1;
          load_val_o = {make_pid(TYPE_DAT), {(SH_W-PID_W){1'b0}}};
        end
        ST_DAT_PID, ST_PAYLOAD: begin
          if (idx_q != len_q) begin
            st_d = ST_PAYLOAD; cnt_d = CW'(BYTE_W-1); idx_d = idx_q + 1'b1;
            load_val_o = {rd_data_i, {(SH_W-BYTE_W){1'b0}}};
          end else begin
            st_d = ST_DAT_CRC; cnt_d = CW'(CRC_W-1);
            load_val_o = {crc_next_i, {(SH_W-CRC_W){1'b0}}};
          end
        end
        default: begin
          st_d = ST_IDLE; load_o = 1'b0;
        end
      endcase
    end else if (st_q != ST_IDLE) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; addr_q <= '0; len_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d;
      if (start_evt) begin
        addr_q <= addr_i;
        len_q  <= len_i;
      end
    end
  end

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st_q == ST_SYNC));
  a_r3_pid_check: assert property (@(posedge clk) disable iff (!rst_n)
    crc_clear_o |-> ((load_val_o[SH_W-1 -: 4] ^ load_val_o[SH_W-5 -: 4]) == 4'hF));
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q <= len_q));
  a_r8_zero_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DAT_PID && field_last && len_q == '0) |=> (st_q == ST_DAT_CRC));
  a_r9_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DAT_CRC && field_last) |=> !busy_o);
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(addr_q) && $stable(len_q)));
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [LEN_W-1:0]  rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              ser_o,
  output logic              ser_valid_o,
  output logic              busy_o
);
  logic             load, crc_clear, hash_en, busy;
  logic [SH_W-1:0]  load_val;
  logic [CRC_W-1:0] crc_cur, crc_next;
  fld_e             state;

  frm_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .len_i(len_i),
    .rd_data_i(rd_data_i), .crc_next_i(crc_next), .rd_addr_o(rd_addr_o),
    .load_o(load), .load_val_o(load_val), .crc_clear_o(crc_clear),
    .hash_en_o(hash_en), .busy_o(busy), .state_o(state)
  );

  frm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .val_i(load_val),
    .shift_en_i(busy), .ser_o(ser_o)
  );

  frm_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .clear_i(crc_clear), .en_i(hash_en),
    .bit_i(ser_o), .crc_o(crc_cur), .crc_next_o(crc_next)
  );

  assign busy_o      = busy;
  assign ser_valid_o = busy;

  // R5 and R7: each packet's CRC starts from the seed while its identifier goes out
  a_r5_seed_at_pid: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SOF_PID || state == ST_DAT_PID) |-> (crc_cur == CRC_SEED));
  // R7: no hashing while a CRC field is on the line
  a_r7_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DAT_CRC || state == ST_SOF_CRC) |-> !hash_en);
endmodule

// File: tb/tb_frame_serializer.sv
`timescale 1ns/1ps
module tb_frame_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [15:0] len_i = '0;
  logic [15:0] rd_addr_o;
  logic [7:0]  rd_data_i;
  logic        ser_o, ser_valid_o, busy_o;

  logic [7:0] mem [0:255];
  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] exp_v[$];
  int          exp_w[$];
  string       exp_t[$];
  logic [31:0] acc = '0;
  int          nb = 0;

  always #2.5 clk = ~clk;
  assign rd_data_i = mem[rd_addr_o[7:0]];

  frame_serializer dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .len_i(len_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .ser_o(ser_o),
    .ser_valid_o(ser_valid_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic push(input logic [31:0] v, input int w, input string t);
    exp_v.push_back(v); exp_w.push_back(w); exp_t.push_back(t);
  endtask

  task automatic expect_frame(input logic [31:0] a, input int n);
    logic [15:0] c;
    push(32'hAAAA5555, 32, "R2 sync word");
    push(32'h1E, 8, "R3 SOF PID");
    push(a, 32, "R4 address");
    push(n, 16, "R4 length");
    c = 16'hFFFF;
    for (int k = 3; k >= 0; k--) c = crc_byte(c, a[k*8 +: 8]);
    c = crc_byte(c, n[15:8]);
    c = crc_byte(c, n[7:0]);
    push(c, 16, "R5 SOF CRC");
    push(32'h2D, 8, "R3 DATA PID");
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      push(mem[k], 8, "R6 payload byte");
      c = crc_byte(c, mem[k]);
    end
    push(c, 16, (n == 0) ? "R8 zero-length CRC" : "R7 DATA CRC");
  endtask

  // scoreboard monitor: gathers bits per expected field and compares
  always @(negedge clk) begin
    if (rst_n && ser_valid_o) begin
      acc = {acc[30:0], ser_o};
      nb++;
      if (exp_v.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 bit outside frame: actual %0b expected none", ser_o);
        nb = 0; acc = '0;
      end else if (nb == exp_w[0]) begin
        check(exp_t[0], acc, exp_v[0]);
        void'(exp_v.pop_front()); void'(exp_w.pop_front()); void'(exp_t.pop_front());
        nb = 0; acc = '0;
      end
    end
  end

  task automatic send(input logic [31:0] a, input int n, input int seed, input bit disturb,
                      input bit known);
    int cyc;
    if (!known) for (int k = 0; k < 256; k++) mem[k] = 8'((k * 37 + seed * 11) ^ seed);
    expect_frame(a, n);
    if (known) exp_v[exp_v.size()-1] = 32'h29B1;
    @(negedge clk);
    addr_i = a; len_i = 16'(n); sel_i = 1'b1;
    @(negedge clk);
    sel_i = 1'b0;
    cyc = 0;
    while (busy_o) begin
      cyc++;
      if (disturb && cyc == 40) begin sel_i = 1'b1; addr_i = ~a; len_i = 16'(n + 3); end
      if (disturb && cyc == 41) sel_i = 1'b0;
      if (disturb && cyc == 100) begin sel_i = 1'b1; addr_i = 32'h0; end
      if (disturb && cyc == 101) sel_i = 1'b0;
      @(negedge clk);
    end
    check("R9 busy cycle count", cyc, 128 + 8 * n);
    check("R9 all fields sent", exp_v.size(), 0);
    @(negedge clk);
    check("R10 no extra frame", {ser_valid_o, busy_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy/valid/ser", {busy_o, ser_valid_o, ser_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {busy_o, ser_valid_o, ser_o}, 0);

    send(32'h1234_5678, 4, 1, 0, 0);
    send(32'hDEAD_BEEF, 0, 2, 0, 0);       // R8
    send(32'h0000_0001, 1, 3, 0, 0);       // R6 single byte
    for (int k = 0; k < 9; k++) mem[k] = 8'h31 + 8'(k);
    send(32'hCAFE_0009, 9, 0, 0, 1);       // R7 known vector
    send(32'h8000_00FF, 20, 5, 1, 0);      // R10 disturbance mid-frame

    // R11: select held high
    for (int k = 0; k < 256; k++) mem[k] = 8'(k ^ 8'h5A);
    expect_frame(32'hA5A5_0003, 3);
    expect_frame(32'hA5A5_0003, 3);
    begin
      int gap;
      @(negedge clk);
      addr_i = 32'hA5A5_0003; len_i = 16'd3; sel_i = 1'b1;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      gap = 0;
      while (!busy_o && gap < 10) begin gap++; @(negedge clk); end
      sel_i = 1'b0;
      check("R11 idle gap with select held", gap, 1);
      while (busy_o) @(negedge clk);
      check("R11 both frames sent", exp_v.size(), 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule